// File: doc/BRIEF.md
# Serial Converter Port with Power-Mode Sequencing

This block is the digital side of a 12-bit serial sampling converter. It watches an active-low conversion-start strobe and a serial clock, both sampled by the chip's system clock, and runs a sixteen-clock conversion frame. During the frame it holds the input stage and shifts the result out MSB first on a data line with a separate output enable. A static select input chooses between a straight-binary result and a two's-complement result.

The block also tracks three power modes. The mode changes only according to how many serial-clock rising edges have passed when the strobe returns high. An early return moves the block from running into light power-down, and from light power-down into deep power-down. Holding the strobe low for at least fourteen rising edges brings either power-down mode back to running. The converter core is a stub that supplies a 12-bit sample word. Analog behaviour and real current control are not modelled.

Top module: `adc_port_ctrl`

## Requirements
- R1: After reset, mode is 2'b00 (running), the output enable is low and the hold signal is low.
- R2: In running mode, a falling strobe edge makes the output enable high, the data line 0 and the hold signal high on the next system clock.
- R3: After k serial-clock falling edges in a frame (k = 0..15), the data line carries bit 15-k of the word {2'b00, result[11:0], 2'b00}: two leading zeros, result bit 11 first, then zeros.
- R4: With the select input at 0 the result equals the sample word. With it at 1 the result equals the sample word with bit 11 inverted (two's complement of an offset-coded sample).
- R5: If the strobe rises after 3 to 13 serial-clock rising edges while running, the mode becomes 2'b01 (light power-down) and the output enable and hold go low.
- R6: The same early return while in light power-down moves the mode to 2'b10 (deep power-down), and while in deep power-down it leaves the mode at 2'b10. Running mode never goes straight to 2'b10, and mode 2'b11 never appears.
- R7: In either power-down mode, a strobe rise after 14 or more rising edges returns the mode to 2'b00.
- R8: If the strobe is still low at the 16th serial-clock falling edge, hold drops but the output enable stays high. It goes low on the next serial-clock rise or strobe rise.
- R9: If the strobe rises after 14 or 15 rising edges while running, the frame completes with the output enable high, and it stays high after the 16th falling edge until the next frame starts.
- R10: While in either power-down mode, the output enable and hold stay low, including through a strobe-low frame.
- R11: A strobe rise after fewer than 3 rising edges ends the frame with the mode unchanged and the output enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples strobe and serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnvst_n | input | 1 | Active-low conversion-start strobe |
| sclk | input | 1 | Serial clock |
| sample | input | 12 | Offset-coded sample word from the converter core |
| bipolar | input | 1 | Result format select: 0 straight binary, 1 two's complement |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Output enable for the serial data line |
| hold | output | 1 | Track (0) / hold (1) control for the input stage |
| mode | output | 2 | Power mode: 00 running, 01 light power-down, 10 deep power-down |

## Verification
The bench probes the abort-window boundaries at 2, 3, 13 and 14 rising edges. A design with an off-by-one count would power down on a valid frame, or miss a power-down request. It runs the abort sequence three times in a row, so a design that jumps straight to deep power-down, or wraps past it, shows a wrong mode code. It also covers the end of a frame with the strobe both low and high at the 16th falling edge. A design that releases the line too early, or too late, would break bus sharing or back-to-back conversions. Random frames check every bit position in both formats, which exposes a shifted or misaligned result word.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_LIGHT = 2'b01,
        MODE_DEEP  = 2'b10
    } pwr_mode_e;

endpackage

// File: rtl/adc_port_edge.sv
module adc_port_edge #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = din;
        rise   = din & ~prev_q;
        fall   = ~din & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RESET_VAL;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/adc_port_fmt.sv
module adc_port_fmt #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              bipolar,
    output logic [DATA_W-1:0] code
);
    always_comb begin
        code             = raw;
        code[DATA_W-1]   = raw[DATA_W-1] ^ bipolar;
    end
endmodule

// File: rtl/adc_port_ctrl.sv
module adc_port_ctrl #(
    parameter int DATA_W    = 12,
    parameter int FRAME_LEN = 16,
    parameter int LEAD      = 2,
    parameter int PD_MIN    = 3,
    parameter int EXIT_MIN  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnvst_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample,
    input  logic              bipolar,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              hold,
    output logic [1:0]        mode
);
    import adc_port_pkg::*;

    localparam int CNT_W = $clog2(FRAME_LEN + 1);
    localparam int TAIL  = FRAME_LEN - LEAD - DATA_W;
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] PD_LO     = CNT_W'(PD_MIN);
    localparam logic [CNT_W-1:0] EXIT_LO   = CNT_W'(EXIT_MIN);

    typedef struct packed {
        pwr_mode_e              mode;
        logic                   in_frame;
        logic [CNT_W-1:0]       rise_cnt;
        logic [CNT_W-1:0]       fall_cnt;
        logic [FRAME_LEN-1:0]   shift;
        logic                   oe;
        logic                   hold;
        logic                   rel;
    } port_state_t;

    port_state_t s_d, s_q;

    logic cnv_rise, cnv_fall, sclk_rise, sclk_fall;
    logic [DATA_W-1:0] code;

    adc_port_edge #(.RESET_VAL(1'b1)) u_cnv_edge (
        .clk(clk), .rst_n(rst_n), .din(cnvst_n), .rise(cnv_rise), .fall(cnv_fall)
    );

    adc_port_edge #(.RESET_VAL(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .din(sclk), .rise(sclk_rise), .fall(sclk_fall)
    );

    adc_port_fmt #(.DATA_W(DATA_W)) u_fmt (
        .raw(sample), .bipolar(bipolar), .code(code)
    );

    always_comb begin
        s_d = s_q;
        if (cnv_fall) begin
            s_d.in_frame = 1'b1;
            s_d.rise_cnt = '0;
            s_d.fall_cnt = '0;
            s_d.rel      = 1'b0;
            if (s_q.mode == MODE_RUN) begin
                s_d.oe    = 1'b1;
                s_d.hold  = 1'b1;
                s_d.shift = FRAME_LEN'(code) << TAIL;
            end else begin
                s_d.oe    = 1'b0;
                s_d.hold  = 1'b0;
            end
        end else begin
            if (sclk_rise) begin
                if (s_q.rel) begin
                    s_d.oe  = 1'b0;
                    s_d.rel = 1'b0;
                end
                if (s_q.in_frame && s_q.rise_cnt != CNT_MAX)
                    s_d.rise_cnt = s_q.rise_cnt + 1'b1;
            end
            if (sclk_fall && s_q.in_frame && s_q.fall_cnt != CNT_MAX) begin
                s_d.shift    = s_q.shift << 1;
                s_d.fall_cnt = s_q.fall_cnt + 1'b1;
                if (s_q.fall_cnt == LAST_FALL) begin
                    s_d.hold = 1'b0;
                    if (!cnvst_n) s_d.rel = s_q.oe;
                    else          s_d.in_frame = 1'b0;
                end
            end
            if (cnv_rise) begin
                if (s_q.in_frame) begin
                    if (s_q.rise_cnt < PD_LO) begin
                        s_d.oe = 1'b0; s_d.hold = 1'b0;
                        s_d.in_frame = 1'b0; s_d.rel = 1'b0;
                    end else if (s_q.rise_cnt < EXIT_LO) begin
                        s_d.oe = 1'b0; s_d.hold = 1'b0;
                        s_d.in_frame = 1'b0; s_d.rel = 1'b0;
                        s_d.mode = (s_q.mode == MODE_RUN) ? MODE_LIGHT : MODE_DEEP;
                    end else if (s_q.mode != MODE_RUN) begin
                        s_d.mode = MODE_RUN;
                        s_d.in_frame = 1'b0;
                    end else if (s_q.fall_cnt == CNT_MAX) begin
                        s_d.oe = 1'b0;
                        s_d.in_frame = 1'b0;
                        s_d.rel = 1'b0;
                    end
                end else if (s_q.rel) begin
                    s_d.oe  = 1'b0;
                    s_d.rel = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode     <= MODE_RUN;
            s_q.in_frame <= 1'b0;
            s_q.rise_cnt <= '0;
            s_q.fall_cnt <= '0;
            s_q.shift    <= '0;
            s_q.oe       <= 1'b0;
            s_q.hold     <= 1'b0;
            s_q.rel      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sdo    = s_q.oe & s_q.shift[FRAME_LEN-1];
    assign sdo_oe = s_q.oe;
    assign hold   = s_q.hold;
    assign mode   = s_q.mode;
endmodule

// File: rtl/adc_port_chk.sv
module adc_port_chk #(
    parameter int CNT_W   = 5,
    parameter int PD_MIN  = 3,
    parameter int EXIT_MIN = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnvst_n,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             hold,
    input logic [1:0]       mode,
    input logic             inf,
    input logic [CNT_W-1:0] rcnt
);
    p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);

    p_no_direct_deep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |-> ($past(mode) != 2'b00));

    p_pd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00) |-> (!sdo_oe && !hold));

    p_start_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cnvst_n) && mode == 2'b00) |=> (sdo_oe && hold && !sdo));

    p_abort_light_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cnvst_n) && inf && mode == 2'b00 &&
         rcnt >= CNT_W'(PD_MIN) && rcnt < CNT_W'(EXIT_MIN))
        |=> (mode == 2'b01 && !sdo_oe));
endmodule

bind adc_port_ctrl adc_port_chk #(.CNT_W(CNT_W), .PD_MIN(PD_MIN), .EXIT_MIN(EXIT_MIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnvst_n(cnvst_n), .sdo(sdo), .sdo_oe(sdo_oe),
    .hold(hold), .mode(mode), .inf(s_q.in_frame), .rcnt(s_q.rise_cnt)
);

// File: tb/sim_adc_port_ctrl.sv
module sim_adc_port_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnvst_n = 1'b1;
    logic sclk = 1'b0;
    logic [11:0] sample = '0;
    logic bipolar = 1'b0;
    logic sdo, sdo_oe, hold;
    logic [1:0] mode;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    adc_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cnvst_n(cnvst_n), .sclk(sclk),
        .sample(sample), .bipolar(bipolar), .sdo(sdo), .sdo_oe(sdo_oe),
        .hold(hold), .mode(mode)
    );

    function automatic logic exp_bit(logic [11:0] w, logic bip, int k);
        logic [11:0] r;
        logic [15:0] f;
        r = bip ? (w ^ 12'h800) : w;
        f = {2'b00, r, 2'b00};
        return f[15-k];
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_cycle();
        sclk = 1'b1; tick(2);
        sclk = 1'b0; tick(2);
    endtask

    task automatic strobe_low();
        cnvst_n = 1'b0; tick(1);
    endtask

    task automatic strobe_high();
        cnvst_n = 1'b1; tick(1);
    endtask

    // Frame with n rising edges, then strobe rise; no data checks
    task automatic short_frame(int n);
        strobe_low();
        for (int i = 0; i < n; i++) sclk_cycle();
        strobe_high();
    endtask

    // Full frame with strobe low; checks the whole stream (R2, R3, R4, R8)
    task automatic full_frame(logic [11:0] w, logic bip, bit end_by_sclk);
        sample = w; bipolar = bip;
        tick(1);
        strobe_low();
        chk("R2 oe", {3'b0, sdo_oe}, 4'h1);
        chk("R2 hold", {3'b0, hold}, 4'h1);
        chk("R3 R4 bit0", {3'b0, sdo}, {3'b0, exp_bit(w, bip, 0)});
        for (int k = 1; k <= 16; k++) begin
            sclk_cycle();
            if (k < 16)
                chk("R3 R4 bit", {3'b0, sdo}, {3'b0, exp_bit(w, bip, k)});
        end
        chk("R8 oe after 16th fall", {3'b0, sdo_oe}, 4'h1);
        chk("R8 hold after 16th fall", {3'b0, hold}, 4'h0);
        if (end_by_sclk) begin
            sclk = 1'b1; tick(2);
            chk("R8 release on sclk rise", {3'b0, sdo_oe}, 4'h0);
            sclk = 1'b0; tick(2);
            strobe_high();
        end else begin
            strobe_high();
            chk("R8 release on strobe rise", {3'b0, sdo_oe}, 4'h0);
        end
        chk("R8 mode", {2'b0, mode}, 4'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        tick(3);
        chk("R1 mode", {2'b0, mode}, 4'h0);
        chk("R1 oe", {3'b0, sdo_oe}, 4'h0);
        chk("R1 hold", {3'b0, hold}, 4'h0);
        rst_n = 1'b1;
        tick(2);

        // Directed data patterns
        full_frame(12'hA5C, 1'b0, 1'b1);
        full_frame(12'h800, 1'b1, 1'b0);
        full_frame(12'h001, 1'b0, 1'b0);
        full_frame(12'hFFF, 1'b1, 1'b1);

        // R11: too-short frames leave mode alone
        short_frame(2);
        chk("R11 mode after 2 edges", {2'b0, mode}, 4'h0);
        chk("R11 oe after 2 edges", {3'b0, sdo_oe}, 4'h0);
        short_frame(0);
        chk("R11 mode after 0 edges", {2'b0, mode}, 4'h0);

        // R5: boundary at 3 edges
        short_frame(3);
        chk("R5 light at 3", {2'b0, mode}, 4'h1);
        chk("R5 oe", {3'b0, sdo_oe}, 4'h0);
        chk("R5 hold", {3'b0, hold}, 4'h0);
        // R11 in light power-down
        short_frame(1);
        chk("R11 stay light", {2'b0, mode}, 4'h1);
        // R7 exit at 14
        short_frame(14);
        chk("R7 exit light at 14", {2'b0, mode}, 4'h0);

        // R5 at 13, R6 at 13, R10 quiet
        short_frame(13);
        chk("R5 light at 13", {2'b0, mode}, 4'h1);
        strobe_low();
        chk("R10 oe at start", {3'b0, sdo_oe}, 4'h0);
        chk("R10 hold at start", {3'b0, hold}, 4'h0);
        for (int i = 0; i < 5; i++) begin
            sclk_cycle();
            chk("R10 oe in frame", {3'b0, sdo_oe}, 4'h0);
        end
        strobe_high();
        chk("R6 deep", {2'b0, mode}, 4'h2);
        short_frame(7);
        chk("R6 deep stays", {2'b0, mode}, 4'h2);
        strobe_low();
        for (int i = 0; i < 20; i++) sclk_cycle();
        chk("R10 oe long deep frame", {3'b0, sdo_oe}, 4'h0);
        strobe_high();
        chk("R7 exit deep", {2'b0, mode}, 4'h0);

        // R9: strobe rises at 14 and at 15, back-to-back frames
        for (int n = 14; n <= 15; n++) begin
            logic [11:0] w;
            w = 12'($urandom);
            sample = w; bipolar = 1'b0;
            tick(1);
            strobe_low();
            for (int k = 1; k <= n; k++) sclk_cycle();
            strobe_high();
            chk("R9 mode", {2'b0, mode}, 4'h0);
            chk("R9 oe after rise", {3'b0, sdo_oe}, 4'h1);
            for (int k = n + 1; k <= 16; k++) begin
                sclk_cycle();
                if (k < 16)
                    chk("R9 R3 bit", {3'b0, sdo}, {3'b0, exp_bit(w, 1'b0, k)});
            end
            chk("R9 oe after frame", {3'b0, sdo_oe}, 4'h1);
            chk("R9 hold after frame", {3'b0, hold}, 4'h0);
            sclk_cycle();
            chk("R9 oe stays", {3'b0, sdo_oe}, 4'h1);
        end
        full_frame(12'h3C3, 1'b1, 1'b0);

        // Random frames and random power sequences
        for (int i = 0; i < 40; i++) begin
            full_frame(12'($urandom), 1'($urandom), 1'($urandom));
        end
        for (int i = 0; i < 10; i++) begin
            int n;
            n = 3 + int'($urandom % 11);
            short_frame(n);
            chk("R5 random abort", {2'b0, mode}, 4'h1);
            short_frame(n);
            chk("R6 random second abort", {2'b0, mode}, 4'h2);
            short_frame(14 + int'($urandom % 6));
            chk("R7 random exit", {2'b0, mode}, 4'h0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule